// File: doc/BRIEF.md
# Multi-Mode Serial I/Q Sample Deframer

This block sits at the entry of a transmit baseband path. It takes samples that arrive bit-serially on a synchronous data link and rebuilds them as parallel in-phase (I) and quadrature (Q) words. The link has a data clock, a strobe and four data lanes. The data clock is the block clock, and every lane and the strobe are sampled on its rising edge. A rising strobe marks where a new I/Q pair begins. A run-time mode input picks one of four lane arrangements:

- one lane carrying I and Q one after the other;
- four lanes carrying 16-bit symbols two bits per beat for each of I and Q;
- two lanes carrying I and Q in parallel;
- a second one-lane interleaved arrangement with the wider symbol set.

A run-time width input picks the symbol size. Combinations of mode and width that are not allowed are reported and never produce output.

Each completed pair is presented on two sign-extended output words together with a one-cycle valid pulse. A strobe that arrives before the current pair is complete discards the partial data, restarts the capture at that bit and sets a sticky framing-error flag. Only reset clears that flag.

Top module: `ssi_deframer`

## Requirements
- R1: Mode code 0 (one-lane): lane 0 carries W bits of I, MSB first, followed directly by W bits of Q, MSB first. The first I bit is the beat on which the strobe is high after having been low in the previous beat.
- R2: In mode 0 the width code selects W: 0 gives 2 bits, 1 gives 8 bits, 3 gives 16 bits. Width code 2 (12 bits) is illegal in mode 0.
- R3: Mode code 1 (four-lane) accepts only width code 3 (16 bits). With any other width code, cfg_err is 1 and out_valid never rises.
- R4: In mode 1 a pair takes 8 beats. On beat b (b = 0 at the strobe), lane 1 carries I bit 15-2b and lane 0 carries I bit 14-2b, so the upper byte of I is sent first. Lanes 3 and 2 carry the Q bits at the same positions.
- R5: Mode code 2 (dual-lane): lane 0 carries I and lane 1 carries Q, both MSB first and in parallel, so a pair takes W beats.
- R6: Mode code 3 (one-lane, wide symbols): I and Q are sent one after the other on lane 0, in the same order as R1.
- R7: In modes 2 and 3 width code 2 gives 12 bits and width code 3 gives 16 bits. Width codes 0 and 1 set cfg_err and produce no output.
- R8: Lane activity while no frame is in progress, including after a frame completes and before the next strobe rise, produces no valid pulse and leaves out_i and out_q unchanged.
- R9: A sample narrower than the output is sign-extended, with its MSB copied into all upper bits of out_i and out_q.
- R10: out_valid is high for exactly one cycle per pair: the cycle after the clock edge that samples the last bit of the pair. out_i and out_q hold their values until the next pair.
- R11: A strobe rise during an incomplete pair sets frame_err and discards the partial pair, which never produces a valid pulse. That beat starts a new pair.
- R12: Reset clears out_i, out_q, out_valid and frame_err. Only reset clears frame_err once it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Lane arrangement: 0 one-lane, 1 four-lane, 2 dual-lane, 3 one-lane wide |
| cfg_width | input | 2 | Symbol width code: 0 = 2, 1 = 8, 2 = 12, 3 = 16 bits |
| strobe | input | 1 | Frame marker; a rise marks the first bit of a pair |
| lanes | input | LANES (4) | Serial data lanes |
| out_i | output | OUT_W (16) | Rebuilt, sign-extended I sample |
| out_q | output | OUT_W (16) | Rebuilt, sign-extended Q sample |
| out_valid | output | 1 | One-cycle pulse per completed pair |
| frame_err | output | 1 | Sticky flag for an early strobe |
| cfg_err | output | 1 | Current mode and width combination is illegal |

## Verification
The bench builds the block with its default four lanes and 16-bit outputs. This keeps the 2-bit one-lane case small enough to sweep every I/Q pair exhaustively. The 8-, 12- and 16-bit cases are covered by arithmetic strides across their ranges, in every mode, with the expected sign-extended words computed in the bench. Every illegal mode and width combination is driven with a full-length frame. An aborted 8-bit frame checks the early-strobe discard, and further frames plus a reset check that the error flag stays set until reset.

// File: rtl/ssi_deframer_pkg.sv
package ssi_deframer_pkg;

   typedef enum logic [1:0] {
      LINK_SE_1L   = 2'd0,
      LINK_SE_4L   = 2'd1,
      LINK_DIFF_2L = 2'd2,
      LINK_DIFF_1L = 2'd3
   } link_mode_e;

   typedef enum logic [1:0] {
      SYM_2  = 2'd0,
      SYM_8  = 2'd1,
      SYM_12 = 2'd2,
      SYM_16 = 2'd3
   } sym_width_e;

   localparam int SYM_MAX = 16;

   function automatic int unsigned sym_bits(sym_width_e w);
      case (w)
         SYM_2:   return 2;
         SYM_8:   return 8;
         SYM_12:  return 12;
         default: return 16;
      endcase
   endfunction

   function automatic logic width_legal(link_mode_e m, sym_width_e w);
      case (m)
         LINK_SE_1L: return (w != SYM_12);
         LINK_SE_4L: return (w == SYM_16);
         default:    return (w == SYM_12) || (w == SYM_16);
      endcase
   endfunction

endpackage

// File: rtl/ssi_frame_ctl.sv
module ssi_frame_ctl #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             legal,
   input  logic             strobe,
   input  logic [CNT_W-1:0] beats,
   output logic             active,
   output logic [CNT_W-1:0] pos,
   output logic             last,
   output logic             frame_err
);

   logic             strobe_q;
   logic             in_frame;
   logic [CNT_W-1:0] cnt;
   logic             rise;
   logic             start;

   always_comb begin
      rise   = strobe & ~strobe_q;
      start  = legal & rise;
      active = legal & (start | in_frame);
      pos    = start ? '0 : cnt;
      last   = active && (pos == beats - CNT_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q  <= 1'b0;
         in_frame  <= 1'b0;
         cnt       <= '0;
         frame_err <= 1'b0;
      end else begin
         strobe_q <= strobe;
         if (start && in_frame)
            frame_err <= 1'b1;
         if (!legal) begin
            in_frame <= 1'b0;
            cnt      <= '0;
         end else if (last) begin
            in_frame <= 1'b0;
            cnt      <= '0;
         end else if (start) begin
            in_frame <= 1'b1;
            cnt      <= CNT_W'(1);
         end else if (in_frame) begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/ssi_shift.sv
module ssi_shift #(
   parameter int SYM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic             step2,
   input  logic [1:0]       bits,
   output logic [SYM_W-1:0] nxt
);

   logic [SYM_W-1:0] val;
   logic [SYM_W-1:0] base;
   logic [SYM_W-1:0] shifted;

   always_comb begin
      base    = clr ? '0 : val;
      shifted = step2 ? {base[SYM_W-3:0], bits} : {base[SYM_W-2:0], bits[0]};
      nxt     = en ? shifted : val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val <= '0;
      else        val <= nxt;
   end

endmodule

// File: rtl/ssi_sample_out.sv
module ssi_sample_out
   import ssi_deframer_pkg::*;
#(
   parameter int OUT_W = 16,
   parameter int SYM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  sym_width_e       width,
   input  logic [SYM_W-1:0] raw_i,
   input  logic [SYM_W-1:0] raw_q,
   output logic [OUT_W-1:0] out_i,
   output logic [OUT_W-1:0] out_q,
   output logic             out_valid
);

   function automatic logic [OUT_W-1:0] sext(logic [SYM_W-1:0] r, sym_width_e w);
      case (w)
         SYM_2:   return {{(OUT_W-2){r[1]}}, r[1:0]};
         SYM_8:   return {{(OUT_W-8){r[7]}}, r[7:0]};
         SYM_12:  return {{(OUT_W-12){r[11]}}, r[11:0]};
         default: return {{(OUT_W-SYM_W){r[SYM_W-1]}}, r};
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_i     <= '0;
         out_q     <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= load;
         if (load) begin
            out_i <= sext(raw_i, width);
            out_q <= sext(raw_q, width);
         end
      end
   end

endmodule

// File: rtl/ssi_deframer.sv
module ssi_deframer
   import ssi_deframer_pkg::*;
#(
   parameter int OUT_W = 16,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_mode,
   input  logic [1:0]       cfg_width,
   input  logic             strobe,
   input  logic [LANES-1:0] lanes,
   output logic [OUT_W-1:0] out_i,
   output logic [OUT_W-1:0] out_q,
   output logic             out_valid,
   output logic             frame_err,
   output logic             cfg_err
);

   localparam int SYM_W = SYM_MAX;
   localparam int CNT_W = $clog2(2 * SYM_W + 1);
   localparam int N_CH  = 2;

   if (OUT_W < SYM_W) begin : g_bad_out_w
      $error("ssi_deframer: OUT_W must be at least the widest symbol");
   end
   if (LANES != 4) begin : g_bad_lanes
      $error("ssi_deframer: lane steering is defined for exactly four lanes");
   end

   link_mode_e       mode;
   sym_width_e       wsel;
   logic             legal;
   logic [CNT_W-1:0] wbits;
   logic [CNT_W-1:0] beats;
   logic             active;
   logic             last;
   logic [CNT_W-1:0] pos;

   logic [N_CH-1:0]  ch_en;
   logic [N_CH-1:0]  ch_clr;
   logic             step2;
   logic [1:0]       ch_bits [N_CH];
   logic [SYM_W-1:0] ch_nxt  [N_CH];

   always_comb begin
      mode    = link_mode_e'(cfg_mode);
      wsel    = sym_width_e'(cfg_width);
      legal   = width_legal(mode, wsel);
      cfg_err = ~legal;
      wbits   = CNT_W'(sym_bits(wsel));
   end

   // Per-mode steering of lanes to the I and Q shifters
   always_comb begin
      beats      = wbits;
      step2      = 1'b0;
      ch_en      = '0;
      ch_clr     = '0;
      ch_bits[0] = {1'b0, lanes[0]};
      ch_bits[1] = {1'b0, lanes[0]};
      case (mode)
         LINK_SE_4L: begin
            beats      = wbits >> 1;
            step2      = 1'b1;
            ch_en      = {N_CH{active}};
            ch_clr     = {N_CH{pos == '0}};
            ch_bits[0] = {lanes[1], lanes[0]};
            ch_bits[1] = {lanes[3], lanes[2]};
         end
         LINK_DIFF_2L: begin
            ch_en      = {N_CH{active}};
            ch_clr     = {N_CH{pos == '0}};
            ch_bits[1] = {1'b0, lanes[1]};
         end
         default: begin
            beats     = wbits << 1;
            ch_en[0]  = active && (pos < wbits);
            ch_en[1]  = active && (pos >= wbits);
            ch_clr[0] = (pos == '0);
            ch_clr[1] = (pos == wbits);
         end
      endcase
   end

   ssi_frame_ctl #(.CNT_W(CNT_W)) i_frame_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .legal     (legal),
      .strobe    (strobe),
      .beats     (beats),
      .active    (active),
      .pos       (pos),
      .last      (last),
      .frame_err (frame_err)
   );

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
      ssi_shift #(.SYM_W(SYM_W)) i_shift (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (ch_en[ch]),
         .clr   (ch_clr[ch]),
         .step2 (step2),
         .bits  (ch_bits[ch]),
         .nxt   (ch_nxt[ch])
      );
   end

   ssi_sample_out #(.OUT_W(OUT_W), .SYM_W(SYM_W)) i_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (last),
      .width     (wsel),
      .raw_i     (ch_nxt[0]),
      .raw_q     (ch_nxt[1]),
      .out_i     (out_i),
      .out_q     (out_q),
      .out_valid (out_valid)
   );

endmodule

// File: rtl/ssi_deframer_chk.sv
module ssi_deframer_chk #(
   parameter int OUT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cfg_mode,
   input logic [1:0]       cfg_width,
   input logic             strobe,
   input logic [OUT_W-1:0] out_i,
   input logic             out_valid,
   input logic             frame_err
);

   assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   assert_four_lane_only16_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd1 && cfg_width != 2'd3) |=> !out_valid);

   assert_diff_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode[1] && !cfg_width[1]) |=> !out_valid);

   assert_ferr_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);

   assert_ferr_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err) |-> $past(strobe));

   assert_sext_two_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cfg_width == 2'd0 && $stable(cfg_width)) |->
         ((out_i[OUT_W-1:1] == '0) || (&out_i[OUT_W-1:1])));

endmodule

bind ssi_deframer ssi_deframer_chk #(.OUT_W(OUT_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_mode  (cfg_mode),
   .cfg_width (cfg_width),
   .strobe    (strobe),
   .out_i     (out_i),
   .out_valid (out_valid),
   .frame_err (frame_err)
);

// File: tb/test_ssi_deframer.sv
module test_ssi_deframer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_mode = 2'd0;
   logic [1:0]  cfg_width = 2'd3;
   logic        strobe = 1'b0;
   logic [3:0]  lanes = 4'd0;
   logic [15:0] out_i, out_q;
   logic        out_valid, frame_err, cfg_err;

   int checks = 0;
   int errors = 0;
   int vc;
   int ce;
   logic [15:0] cap_i, cap_q;

   always #5 clk = ~clk;

   ssi_deframer i_ssi_deframer (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_width(cfg_width),
      .strobe(strobe), .lanes(lanes), .out_i(out_i), .out_q(out_q),
      .out_valid(out_valid), .frame_err(frame_err), .cfg_err(cfg_err)
   );

   function automatic int wb(int wc);
      case (wc)
         0: return 2;
         1: return 8;
         2: return 12;
         default: return 16;
      endcase
   endfunction

   function automatic int nbeats(int m, int wc);
      if (m == 1) return 8;
      if (m == 2) return wb(wc);
      return 2 * wb(wc);
   endfunction

   function automatic int sx(int w, int v);
      int t;
      t = v & ((1 << w) - 1);
      if ((t >> (w - 1)) & 1) t = t - (1 << w);
      return t & 16'hFFFF;
   endfunction

   task automatic chk(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0h expected %0h", req, got, exp);
      end
   endtask

   // Drives nb beats of a frame followed by two idle beats; counts valid pulses.
   task automatic run_frame(int m, int wc, int iv, int qv, int nb);
      int w;
      w  = wb(wc);
      vc = 0;
      for (int b = 0; b < nb + 2; b++) begin
         @(negedge clk);
         if (out_valid) begin
            vc++;
            cap_i = out_i;
            cap_q = out_q;
         end
         if (b == 0) begin
            cfg_mode  = 2'(m);
            cfg_width = 2'(wc);
         end
         strobe = (b == 0);
         lanes  = 4'd0;
         if (b < nb) begin
            case (m)
               1: begin
                  lanes[1] = iv[15 - 2*b];
                  lanes[0] = iv[14 - 2*b];
                  lanes[3] = qv[15 - 2*b];
                  lanes[2] = qv[14 - 2*b];
               end
               2: begin
                  lanes[0] = iv[w - 1 - b];
                  lanes[1] = qv[w - 1 - b];
               end
               default: lanes[0] = (b < w) ? iv[w - 1 - b] : qv[2*w - 1 - b];
            endcase
         end
         if (b == nb + 1) ce = int'(cfg_err);
      end
   endtask

   task automatic good_frame(string req, int m, int wc, int iv, int qv);
      int w;
      w = wb(wc);
      run_frame(m, wc, iv, qv, nbeats(m, wc));
      chk({req, " valid count"}, vc, 1);
      chk({req, " I"}, int'(cap_i), sx(w, iv));
      chk({req, " Q"}, int'(cap_q), sx(w, qv));
   endtask

   task automatic bad_frame(string req, int m, int wc);
      run_frame(m, wc, 16'h5A3C, 16'hC3A5, nbeats(m, wc));
      chk({req, " cfg_err"}, ce, 1);
      chk({req, " no valid"}, vc, 0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      strobe = 1'b0;
      lanes = 4'd0;
      cfg_mode = 2'd0;
      cfg_width = 2'd3;
      repeat (3) @(negedge clk);
      chk("R12 reset out_valid", int'(out_valid), 0);
      chk("R12 reset frame_err", int'(frame_err), 0);
      chk("R12 reset out_i", int'(out_i), 0);
      chk("R12 reset out_q", int'(out_q), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(1_500_000 * 1ns);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();

      // R1/R2/R9: exhaustive 2-bit one-lane sweep
      for (int i = 0; i < 4; i++)
         for (int q = 0; q < 4; q++)
            good_frame("R1 R2 R9 w2", 0, 0, i, q);
      for (int k = 0; k < 16; k++)
         good_frame("R1 R2 R9 w8", 0, 1, k * 17, 255 - k * 13);
      for (int k = 0; k < 8; k++)
         good_frame("R1 R2 w16", 0, 3, (k * 8191 + 5) & 16'hFFFF, (k * 4099 + 32768) & 16'hFFFF);
      bad_frame("R2 one-lane 12-bit illegal", 0, 2);

      // R4: four-lane
      for (int k = 0; k < 16; k++)
         good_frame("R4 four-lane", 1, 3, (k * 4369 + 7) & 16'hFFFF, (65535 - k * 3001) & 16'hFFFF);
      // R3: four-lane rejects other widths
      for (int wc = 0; wc < 3; wc++)
         bad_frame("R3 four-lane width", 1, wc);

      // R5: dual-lane, 12 and 16 bits
      for (int k = 0; k < 12; k++) begin
         good_frame("R5 R9 dual w12", 2, 2, k * 341, 4095 - k * 297);
         good_frame("R5 dual w16", 2, 3, (k * 5461 + 1) & 16'hFFFF, (k * 2730 + 40000) & 16'hFFFF);
      end
      // R6: single-lane wide interleaved
      for (int k = 0; k < 12; k++) begin
         good_frame("R6 R9 diff1 w12", 3, 2, 4095 - k * 333, k * 300 + 2048);
         good_frame("R6 diff1 w16", 3, 3, (k * 6007) & 16'hFFFF, (65535 - k * 5003) & 16'hFFFF);
      end
      // R7: illegal widths in modes 2 and 3
      for (int m = 2; m < 4; m++)
         for (int wc = 0; wc < 2; wc++)
            bad_frame("R7 narrow width", m, wc);

      // R8: lane activity without a strobe rise
      good_frame("R8 setup", 0, 1, 8'h81, 8'h7E);
      vc = 0;
      for (int b = 0; b < 40; b++) begin
         @(negedge clk);
         if (out_valid) vc++;
         strobe = 1'b0;
         lanes = 4'($urandom);
      end
      @(negedge clk);
      if (out_valid) vc++;
      chk("R8 no valid while idle", vc, 0);
      chk("R8 I held", int'(out_i), sx(8, 8'h81));
      chk("R8 Q held", int'(out_q), sx(8, 8'h7E));
      chk("R10 valid low after pulse", int'(out_valid), 0);

      // R11: early strobe aborts a partial 8-bit frame
      chk("R11 no error before", int'(frame_err), 0);
      run_frame(0, 1, 8'h11, 8'h22, 5);
      chk("R11 partial gives no valid", vc, 0);
      good_frame("R11 restart frame", 0, 1, 8'hC4, 8'h3B);
      chk("R11 frame_err set", int'(frame_err), 1);

      // R12: flag stays set across clean frames until reset
      good_frame("R12 clean frame", 2, 3, 16'h1234, 16'hFEDC);
      chk("R12 frame_err sticky", int'(frame_err), 1);
      do_reset();
      good_frame("R12 after reset", 0, 0, 2, 1);
      chk("R12 frame_err cleared", int'(frame_err), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule